// File: doc/BRIEF.md
# Register-Transfer Arithmetic and Shift Unit

This block is a single-destination register-transfer unit. Each clock cycle it can perform one operation on two W-bit operand words, `opnd_a` and `opnd_b`. It writes the result into the destination register `acc_q`. A 4-bit opcode selects the operation. The result is committed only when `load` is high. When `load` is low, a feedback multiplexer re-selects the current register value, so the clock is never gated.

The unit has one carry-propagate adder, which serves for add, subtract, increment, decrement and twos' complement. For subtraction and negation, an operand is inverted and the carry input is driven to 1. Word-wide bitwise logic and single-bit shifts take separate paths. A shift can be a left shift, a logical right shift or an arithmetic right shift. The bit that falls out of the word is kept in a one-bit register, `spill_q`.

A result appears on `acc_q` and `spill_q` after the rising edge at which `load`, `op`, `opnd_a` and `opnd_b` were sampled. Reset is synchronous and active high.

Top module: `rtu_core`

## Requirements
- R1: A rising edge with `rst` high clears `acc_q` to 0 and `spill_q` to 0, whatever `load` and `op` are.
- R2: A rising edge with `load` low leaves both `acc_q` and `spill_q` unchanged, for every opcode.
- R3: When `load` is high, op 0 writes `opnd_a + opnd_b` and op 1 writes `opnd_a - opnd_b`. Both results wrap modulo 2^W.
- R4: When `load` is high, op 2 writes `opnd_a + 1` and op 3 writes `opnd_a - 1`. Both results wrap modulo 2^W.
- R5: When `load` is high, op 4 writes the ones' complement `~opnd_a` and op 5 writes the twos' complement `-opnd_a` (modulo 2^W).
- R6: When `load` is high, op 6 writes `opnd_a & opnd_b`, op 7 writes `opnd_a | opnd_b`, op 8 writes `opnd_a ^ opnd_b` and op 9 writes `opnd_a` unchanged.
- R7: When `load` is high, op 10 writes `opnd_a` shifted left by one with 0 entering bit 0, and `spill_q` takes the old `opnd_a[W-1]`.
- R8: When `load` is high, op 11 (logical right shift, 0 enters bit W-1) and op 12 (arithmetic right shift, bit W-1 keeps its value) each shift `opnd_a` right by one, and `spill_q` takes `opnd_a[0]`.
- R9: Ops other than 10, 11 and 12 leave `spill_q` unchanged.
- R10: Ops 13, 14 and 15 leave `acc_q` and `spill_q` unchanged, even when `load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Commit enable for this cycle's operation |
| op | input | 4 | Operation code (see requirements) |
| opnd_a | input | W | First operand word |
| opnd_b | input | W | Second operand word |
| acc_q | output | W | Destination register |
| spill_q | output | 1 | Bit shifted out by the last committed shift |

## Verification
The hardest state to observe is a `spill_q` that must survive long runs of non-shift operations, unused opcodes and cycles with `load` low. After reset that bit is 0, so a design that wrongly clears it looks correct. The stimulus therefore first commits shifts with a 1 in the outgoing bit position, then issues arithmetic, logic, unused and non-loading operations and checks that the 1 is still held. Random mixing with roughly one cycle in eight having `load` low keeps driving the unit into this state. Directed cases cover the wrap-around edges: decrement of 0, increment of all ones, negation of 0, and subtraction that borrows.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_INC = 4'd2;
    localparam logic [3:0] OP_DEC = 4'd3;
    localparam logic [3:0] OP_CPL = 4'd4;
    localparam logic [3:0] OP_NEG = 4'd5;
    localparam logic [3:0] OP_AND = 4'd6;
    localparam logic [3:0] OP_OR  = 4'd7;
    localparam logic [3:0] OP_XOR = 4'd8;
    localparam logic [3:0] OP_MOV = 4'd9;
    localparam logic [3:0] OP_SHL = 4'd10;
    localparam logic [3:0] OP_SHR = 4'd11;
    localparam logic [3:0] OP_SAR = 4'd12;

    typedef enum logic [1:0] {
        U_ARITH = 2'd0,
        U_LOGIC = 2'd1,
        U_SHIFT = 2'd2,
        U_NONE  = 2'd3
    } unit_e;

    // second adder input source
    typedef enum logic [1:0] {
        B_PLAIN = 2'd0,
        B_INV   = 2'd1,
        B_ZERO  = 2'd2,
        B_ONES  = 2'd3
    } bsel_e;

    typedef enum logic [1:0] {
        L_AND  = 2'd0,
        L_OR   = 2'd1,
        L_XOR  = 2'd2,
        L_PASS = 2'd3
    } lsel_e;

    typedef enum logic [1:0] {
        S_LEFT  = 2'd0,
        S_LRITE = 2'd1,
        S_ARITE = 2'd2,
        S_RSVD  = 2'd3
    } ssel_e;

    typedef struct packed {
        unit_e unit;
        logic  inv_a;
        bsel_e bsel;
        logic  cin;
        lsel_e lsel;
        ssel_e ssel;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [3:0] code);
        ctl_t c;
        c = '{unit: U_NONE, inv_a: 1'b0, bsel: B_ZERO, cin: 1'b0,
              lsel: L_PASS, ssel: S_RSVD};
        case (code)
            OP_ADD: begin c.unit = U_ARITH; c.bsel = B_PLAIN; end
            OP_SUB: begin c.unit = U_ARITH; c.bsel = B_INV; c.cin = 1'b1; end
            OP_INC: begin c.unit = U_ARITH; c.bsel = B_ZERO; c.cin = 1'b1; end
            OP_DEC: begin c.unit = U_ARITH; c.bsel = B_ONES; end
            OP_CPL: begin c.unit = U_ARITH; c.inv_a = 1'b1; c.bsel = B_ZERO; end
            OP_NEG: begin c.unit = U_ARITH; c.inv_a = 1'b1; c.bsel = B_ZERO; c.cin = 1'b1; end
            OP_AND: begin c.unit = U_LOGIC; c.lsel = L_AND; end
            OP_OR:  begin c.unit = U_LOGIC; c.lsel = L_OR; end
            OP_XOR: begin c.unit = U_LOGIC; c.lsel = L_XOR; end
            OP_MOV: begin c.unit = U_LOGIC; c.lsel = L_PASS; end
            OP_SHL: begin c.unit = U_SHIFT; c.ssel = S_LEFT; end
            OP_SHR: begin c.unit = U_SHIFT; c.ssel = S_LRITE; end
            OP_SAR: begin c.unit = U_SHIFT; c.ssel = S_ARITE; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rtu_addsub.sv
module rtu_addsub
    import rtu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_a,
    input  bsel_e        bsel,
    input  logic         cin,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] x, y;
    logic [W:0]   cy;

    always_comb begin
        x = inv_a ? ~a_i : a_i;
        case (bsel)
            B_PLAIN: y = b_i;
            B_INV:   y = ~b_i;
            B_ZERO:  y = '0;
            default: y = '1;
        endcase
    end

    assign cy[0] = cin;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign sum_o[g]  = x[g] ^ y[g] ^ cy[g];
        assign cy[g+1]   = (x[g] & y[g]) | (cy[g] & (x[g] ^ y[g]));
    end

    // R3: subtract path: adding b back must give a again
    always_comb begin
        if (!inv_a && bsel == B_INV && cin)
            p_sub_inverse_r3: assert (W'(sum_o + b_i) == a_i);
    end

    // R5: negate path: result plus a wraps to zero
    always_comb begin
        if (inv_a && bsel == B_ZERO && cin)
            p_neg_cancels_r5: assert (W'(sum_o + a_i) == '0);
    end

endmodule

// File: rtl/rtu_bitwise.sv
module rtu_bitwise
    import rtu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  lsel_e        lsel,
    output logic [W-1:0] res_o
);
    always_comb begin
        case (lsel)
            L_AND:   res_o = a_i & b_i;
            L_OR:    res_o = a_i | b_i;
            L_XOR:   res_o = a_i ^ b_i;
            default: res_o = a_i;
        endcase
    end

    // R6: xor result never has a bit set where and has one
    always_comb begin
        if (lsel == L_XOR)
            p_xor_disjoint_r6: assert ((res_o & a_i & b_i) == '0);
    end

endmodule

// File: rtl/rtu_shift1.sv
module rtu_shift1
    import rtu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  ssel_e        ssel,
    output logic [W-1:0] res_o,
    output logic         out_bit
);
    localparam int MSB = W - 1;

    always_comb begin
        case (ssel)
            S_LEFT: begin
                res_o   = {a_i[MSB-1:0], 1'b0};
                out_bit = a_i[MSB];
            end
            S_LRITE: begin
                res_o   = {1'b0, a_i[MSB:1]};
                out_bit = a_i[0];
            end
            S_ARITE: begin
                res_o   = {a_i[MSB], a_i[MSB:1]};
                out_bit = a_i[0];
            end
            default: begin
                res_o   = a_i;
                out_bit = 1'b0;
            end
        endcase
    end

    // R8: arithmetic right shift keeps the sign bit
    always_comb begin
        if (ssel == S_ARITE)
            p_sign_kept_r8: assert (res_o[MSB] == a_i[MSB]);
    end

endmodule

// File: rtl/rtu_hold.sv
module rtu_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // feedback multiplexer: re-select own output when not loading
    assign nxt = ld ? d : q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    p_clear_r1: assert property (@(posedge clk) rst |=> (q == '0));

    p_keep_r2: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q));

endmodule

// File: rtl/rtu_core.sv
module rtu_core
    import rtu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [3:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] acc_q,
    output logic         spill_q
);
    ctl_t         ctl;
    logic [W-1:0] arith_res, logic_res, shift_res, result;
    logic         shift_bit;
    logic         wr_acc, wr_spill;

    assign ctl = decode_op(op);

    rtu_addsub #(.W(W)) u_add (
        .a_i(opnd_a), .b_i(opnd_b), .inv_a(ctl.inv_a),
        .bsel(ctl.bsel), .cin(ctl.cin), .sum_o(arith_res)
    );

    rtu_bitwise #(.W(W)) u_log (
        .a_i(opnd_a), .b_i(opnd_b), .lsel(ctl.lsel), .res_o(logic_res)
    );

    rtu_shift1 #(.W(W)) u_shf (
        .a_i(opnd_a), .ssel(ctl.ssel), .res_o(shift_res), .out_bit(shift_bit)
    );

    always_comb begin
        case (ctl.unit)
            U_ARITH: result = arith_res;
            U_LOGIC: result = logic_res;
            U_SHIFT: result = shift_res;
            default: result = acc_q;
        endcase
    end

    assign wr_acc   = load && (ctl.unit != U_NONE);
    assign wr_spill = load && (ctl.unit == U_SHIFT);

    rtu_hold #(.W(W)) u_acc (
        .clk(clk), .rst(rst), .ld(wr_acc), .d(result), .q(acc_q)
    );

    rtu_hold #(.W(1)) u_spill (
        .clk(clk), .rst(rst), .ld(wr_spill), .d(shift_bit), .q(spill_q)
    );

    p_spill_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (op < OP_SHL) |=> $stable(spill_q));

    p_unused_op_r10: assert property (@(posedge clk) disable iff (rst)
        (op > OP_SAR) |=> ($stable(acc_q) && $stable(spill_q)));

    p_shl_out_r7: assert property (@(posedge clk) disable iff (rst)
        (load && op == OP_SHL) |=> (spill_q == $past(opnd_a[W-1])
                                    && acc_q[0] == 1'b0));

endmodule

// File: tb/sim_rtu_core.sv
`timescale 1ns/1ps
module sim_rtu_core;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [3:0]   op = 4'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] acc_q;
    logic         spill_q;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [W-1:0] m_acc = '0;
    logic         m_sp  = 1'b0;

    rtu_core #(.W(W)) u0 (
        .clk(clk), .rst(rst), .load(load), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_q(acc_q), .spill_q(spill_q)
    );

    always #2 clk = ~clk;

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1:             return "R3";
            4'd2, 4'd3:             return "R4";
            4'd4, 4'd5:             return "R5";
            4'd6, 4'd7, 4'd8, 4'd9: return "R6";
            4'd10:                  return "R7";
            4'd11, 4'd12:           return "R8";
            default:                return "R10";
        endcase
    endfunction

    // reference model built from the requirement text
    task automatic model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] r;
        r = m_acc;
        case (o)
            4'd0:  r = x + y;
            4'd1:  r = x - y;
            4'd2:  r = x + 1'b1;
            4'd3:  r = x - 1'b1;
            4'd4:  r = ~x;
            4'd5:  r = -x;
            4'd6:  r = x & y;
            4'd7:  r = x | y;
            4'd8:  r = x ^ y;
            4'd9:  r = x;
            4'd10: begin r = x << 1; m_sp = x[W-1]; end
            4'd11: begin r = x >> 1; m_sp = x[0]; end
            4'd12: begin r = {x[W-1], x[W-1:1]}; m_sp = x[0]; end
            default: r = m_acc;
        endcase
        m_acc = r;
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (acc_q !== m_acc || spill_q !== m_sp) begin
            n_bad++;
            $display("FAIL %s acc=%h expected %h spill=%b expected %b",
                     tag, acc_q, m_acc, spill_q, m_sp);
        end
    endtask

    task automatic step(input logic l, input logic [3:0] o,
                        input logic [W-1:0] x, input logic [W-1:0] y,
                        input string tag);
        load = l; op = o; opnd_a = x; opnd_b = y;
        @(posedge clk);
        if (l) model(o, x, y);
        @(negedge clk);
        check(tag);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 got=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        m_acc = '0; m_sp = 1'b0;
        check("R1");
        rst = 1'b0;

        // directed corners
        step(1'b1, 4'd0, 8'hF0, 8'h20, "R3");   // wrap add
        step(1'b1, 4'd1, 8'h03, 8'h05, "R3");   // borrow
        step(1'b1, 4'd2, 8'hFF, 8'h00, "R4");   // inc wrap
        step(1'b1, 4'd3, 8'h00, 8'h00, "R4");   // dec wrap
        step(1'b1, 4'd5, 8'h00, 8'h00, "R5");   // neg zero
        step(1'b1, 4'd5, 8'h80, 8'h00, "R5");
        step(1'b1, 4'd4, 8'h5A, 8'h00, "R5");
        step(1'b1, 4'd8, 8'hCC, 8'hAA, "R6");
        step(1'b1, 4'd9, 8'h3C, 8'hFF, "R6");
        step(1'b1, 4'd10, 8'h81, 8'h00, "R7");  // spill becomes 1
        step(1'b1, 4'd0, 8'h01, 8'h01, "R9");   // spill must stay 1
        step(1'b1, 4'd6, 8'hF0, 8'h0F, "R9");
        step(1'b1, 4'd13, 8'h55, 8'h55, "R10");
        step(1'b1, 4'd15, 8'hAA, 8'h00, "R10");
        step(1'b0, 4'd11, 8'h02, 8'h00, "R2");  // no load: spill kept
        step(1'b0, 4'd0, 8'h11, 8'h22, "R2");
        step(1'b1, 4'd12, 8'h82, 8'h00, "R8");  // sign kept, spill 0
        step(1'b1, 4'd11, 8'h81, 8'h00, "R8");  // spill 1
        step(1'b1, 4'd12, 8'h7F, 8'h00, "R8");
        step(1'b1, 4'd14, 8'h00, 8'h00, "R10");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic       l;
            logic [3:0] o;
            l = ($urandom % 8) != 0;
            o = 4'($urandom % 16);
            step(l, o, W'($urandom), W'($urandom), l ? tag_of(o) : "R2");
        end

        // mid-run reset with a loading operation present
        step(1'b1, 4'd10, 8'hFF, 8'h00, "R7");
        rst = 1'b1; load = 1'b1; op = 4'd0; opnd_a = 8'h12; opnd_b = 8'h34;
        @(posedge clk);
        @(negedge clk);
        m_acc = '0; m_sp = 1'b0;
        check("R1");
        rst = 1'b0;
        step(1'b1, 4'd2, 8'h41, 8'h00, "R4");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule